// File: doc/BRIEF.md
# Debug Register Access Guard

This block models the breakpoint and debug-register protection logic of a processor core. It holds a small bank of linear-address breakpoint comparators with a control word and a sticky status word. Every cycle it compares the instruction-fetch and data linear addresses against the enabled comparators. A match raises a debug-exception request and records which comparator fired.

The block also polices access to its own registers. A read or write is honoured only when the core runs at privilege level 0, in management mode or in real-address mode. Any other access becomes a general-protection fault request and touches nothing.

A general-detect enable in the control word turns every later permitted access into a debug trap, so that a handler sees an intruder's attempt before it lands. Entry to the debug handler disarms general detect. The handler re-arms it with an explicit write. Between handler entry and handler exit, breakpoint matches are held off so that the handler's own accesses do not re-trigger it.

Top module: `dbg_guard`

## Requirements
- R1: After reset every breakpoint address, the control word and the status word read as zero, and `dbg_exc`, `gp_fault` and `acc_rd_vld` are low.
- R2: An access (`acc_rd` or `acc_wr`) made with `cpl` not 0 while both `mgmt_mode` and `real_mode` are low raises `gp_fault` for one cycle on the next clock. The addressed register keeps its value and no read data is returned.
- R3: An access is permitted when `cpl` is 0, when `mgmt_mode` is high, or when `real_mode` is high. A permitted write lands on the next clock. A permitted read returns the register on `acc_rdata` with `acc_rd_vld` high one clock later. Register select: 0 to 3 are the breakpoint addresses, 6 is status, 7 is control.
- R4: While control bit 13 (general detect) is set, a permitted access is not performed. Instead, on the next clock `dbg_exc` pulses and status bit 13 is set.
- R5: When an access is both unprivileged and subject to general detect, only `gp_fault` is raised. Status bit 13 is not set and `dbg_exc` stays low.
- R6: A `hnd_entry` pulse clears control bit 13 on the next clock, which takes precedence over a simultaneous control write. The bit stays clear until software writes it again.
- R7: When control bit i (i in 0..3) is set and the fetch address (with `fetch_vld`) or the data address (with `data_vld`) equals breakpoint address i, status bit i is set and `dbg_exc` pulses on the next clock.
- R8: A comparator whose control enable bit is clear never raises `dbg_exc` and never sets its status bit.
- R9: Status bits are sticky. They change only by a permitted write to select 6, which stores the written value masked to bits 0 to 3 and 13. New hits and traps are ORed on top in the same cycle.
- R10: From the clock after `hnd_entry` until the clock after `hnd_exit`, breakpoint matches raise no exception and set no status bits.
- R11: Selects 4 and 5 are subject to the same privilege and general-detect rules, but they read as zero and writes to them change nothing. Control writes keep only bits 0 to 3 and 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpl | input | 2 | Current privilege level |
| mgmt_mode | input | 1 | Core is in management mode |
| real_mode | input | 1 | Core is in real-address mode |
| acc_rd | input | 1 | Debug-register read strobe |
| acc_wr | input | 1 | Debug-register write strobe |
| acc_sel | input | 3 | Register select |
| acc_wdata | input | AW | Write data |
| acc_rdata | output | AW | Read data, valid with acc_rd_vld |
| acc_rd_vld | output | 1 | Read data valid pulse |
| fetch_vld | input | 1 | Instruction fetch address valid |
| fetch_lin | input | AW | Instruction fetch linear address |
| data_vld | input | 1 | Data access address valid |
| data_lin | input | AW | Data access linear address |
| hnd_entry | input | 1 | Debug handler entry pulse |
| hnd_exit | input | 1 | Debug handler exit pulse |
| dbg_exc | output | 1 | Debug exception request pulse |
| gp_fault | output | 1 | General-protection fault request pulse |
| status | output | AW | Status word |

## Verification
The bound checker watches, on every cycle, the privilege split between fault and permitted access. It also checks that general detect turns a permitted access into a trap with the status flag set, that a fault never sets that flag, that handler entry always disarms general detect, and that status bits never fall without a write. The bench's scenarios alone can show that faulting and trapped writes leave the register contents untouched, which only a later read-back reveals. The same holds for comparator matches on either address path, disabled comparators, the suppression window between handler entry and exit, the masking of status and control writes, and the inert selects 4 and 5.

// File: rtl/dbg_guard_pkg.sv
package dbg_guard_pkg;
  // Control word: bits [NBP-1:0] enable comparators, GD_BIT arms general detect
  localparam int unsigned GD_BIT = 13;
  // Status word: bits [NBP-1:0] record matches, BD_BIT records a general-detect trap
  localparam int unsigned BD_BIT = 13;
  localparam int unsigned SEL_W  = 3;

  localparam logic [SEL_W-1:0] SEL_STATUS = 3'd6;
  localparam logic [SEL_W-1:0] SEL_CTRL   = 3'd7;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_FAULT = 2'd1,
    ACC_TRAP  = 2'd2,
    ACC_DO    = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/dbg_access_ctl.sv
module dbg_access_ctl
  import dbg_guard_pkg::*;
(
  input  logic [1:0] cpl,
  input  logic       mgmt_mode,
  input  logic       real_mode,
  input  logic       acc_rd,
  input  logic       acc_wr,
  input  logic       gd_armed,
  output logic       fault,
  output logic       trap,
  output logic       perform
);
  logic      priv_ok;
  logic      any_acc;
  acc_kind_e kind;

  assign priv_ok = mgmt_mode | real_mode | (cpl == 2'd0);
  assign any_acc = acc_rd | acc_wr;

  // Privilege check ranks ahead of the general-detect trap
  always_comb begin
    kind = ACC_NONE;
    if (any_acc) begin
      if (!priv_ok)      kind = ACC_FAULT;
      else if (gd_armed) kind = ACC_TRAP;
      else               kind = ACC_DO;
    end
  end

  assign fault   = (kind == ACC_FAULT);
  assign trap    = (kind == ACC_TRAP);
  assign perform = (kind == ACC_DO);
endmodule

// File: rtl/dbg_bp_cmp.sv
module dbg_bp_cmp #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] bp_addr,
  input  logic          armed,
  input  logic          quiet,
  input  logic          fetch_vld,
  input  logic [AW-1:0] fetch_lin,
  input  logic          data_vld,
  input  logic [AW-1:0] data_lin,
  output logic          hit
);
  logic fetch_eq;
  logic data_eq;

  // Linear addresses are compared directly, before any translation
  assign fetch_eq = fetch_vld && (fetch_lin == bp_addr);
  assign data_eq  = data_vld  && (data_lin  == bp_addr);
  assign hit      = armed && !quiet && (fetch_eq || data_eq);
endmodule

// File: rtl/dbg_guard.sv
module dbg_guard
  import dbg_guard_pkg::*;
#(
  parameter int AW  = 32,
  parameter int NBP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cpl,
  input  logic             mgmt_mode,
  input  logic             real_mode,
  input  logic             acc_rd,
  input  logic             acc_wr,
  input  logic [SEL_W-1:0] acc_sel,
  input  logic [AW-1:0]    acc_wdata,
  output logic [AW-1:0]    acc_rdata,
  output logic             acc_rd_vld,
  input  logic             fetch_vld,
  input  logic [AW-1:0]    fetch_lin,
  input  logic             data_vld,
  input  logic [AW-1:0]    data_lin,
  input  logic             hnd_entry,
  input  logic             hnd_exit,
  output logic             dbg_exc,
  output logic             gp_fault,
  output logic [AW-1:0]    status
);
  // NBP must not exceed 4: selects 0..3 are the only address slots
  localparam logic [AW-1:0] EN_MASK  = (AW'(1) << NBP) - AW'(1);
  localparam logic [AW-1:0] CTL_MASK = EN_MASK | (AW'(1) << GD_BIT);
  localparam logic [AW-1:0] STS_MASK = EN_MASK | (AW'(1) << BD_BIT);

  // Reset synchronizer: assert asynchronously, release on the clock
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  // State
  logic [AW-1:0] bp_q [NBP];
  logic [AW-1:0] ctl_q, sts_q, rdata_q;
  logic          in_hnd_q, exc_q, gp_q, rdv_q;

  // Next state and enables
  logic [NBP-1:0] bp_we;
  logic [NBP-1:0] hit_vec;
  logic [AW-1:0]  ctl_d, sts_d, rdata_d, rd_mux;
  logic           ctl_en, sts_en, sts_wr, hnd_en, hnd_d, rdata_en;
  logic           exc_d, gp_d, rdv_d;
  logic           fault, trap, perform;

  dbg_access_ctl u_acc (
    .cpl       (cpl),
    .mgmt_mode (mgmt_mode),
    .real_mode (real_mode),
    .acc_rd    (acc_rd),
    .acc_wr    (acc_wr),
    .gd_armed  (ctl_q[GD_BIT]),
    .fault     (fault),
    .trap      (trap),
    .perform   (perform)
  );

  genvar gi;
  generate
    for (gi = 0; gi < NBP; gi++) begin : g_bp
      dbg_bp_cmp #(.AW(AW)) u_cmp (
        .bp_addr   (bp_q[gi]),
        .armed     (ctl_q[gi]),
        .quiet     (in_hnd_q),
        .fetch_vld (fetch_vld),
        .fetch_lin (fetch_lin),
        .data_vld  (data_vld),
        .data_lin  (data_lin),
        .hit       (hit_vec[gi])
      );

      assign bp_we[gi] = perform && acc_wr && (acc_sel == SEL_W'(gi));

      always_ff @(posedge clk or negedge rst_sync_n) begin
        if (!rst_sync_n)    bp_q[gi] <= '0;
        else if (bp_we[gi]) bp_q[gi] <= acc_wdata;
      end
    end
  endgenerate

  // Read multiplexer; unlisted selects return zero
  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NBP; i++) begin
      if (acc_sel == SEL_W'(i)) rd_mux = bp_q[i];
    end
    if (acc_sel == SEL_STATUS) rd_mux = sts_q;
    if (acc_sel == SEL_CTRL)   rd_mux = ctl_q;
  end

  always_comb begin
    // Control: software write, handler entry disarms general detect
    ctl_en = (perform && acc_wr && (acc_sel == SEL_CTRL)) || hnd_entry;
    ctl_d  = (perform && acc_wr && (acc_sel == SEL_CTRL)) ? (acc_wdata & CTL_MASK) : ctl_q;
    if (hnd_entry) ctl_d[GD_BIT] = 1'b0;

    // Status: sticky, software write replaces, events OR on top
    sts_wr = perform && acc_wr && (acc_sel == SEL_STATUS);
    sts_d  = sts_wr ? (acc_wdata & STS_MASK) : sts_q;
    sts_d  = sts_d | {{(AW-NBP){1'b0}}, hit_vec};
    if (trap) sts_d[BD_BIT] = 1'b1;
    sts_en = sts_wr || (|hit_vec) || trap;

    // Handler window
    hnd_en = hnd_entry || hnd_exit;
    hnd_d  = hnd_entry;

    // Response pulses
    exc_d    = trap || (|hit_vec);
    gp_d     = fault;
    rdv_d    = perform && acc_rd;
    rdata_en = perform && acc_rd;
    rdata_d  = rd_mux;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctl_q    <= '0;
      sts_q    <= '0;
      in_hnd_q <= 1'b0;
      rdata_q  <= '0;
      exc_q    <= 1'b0;
      gp_q     <= 1'b0;
      rdv_q    <= 1'b0;
    end else begin
      if (ctl_en)   ctl_q    <= ctl_d;
      if (sts_en)   sts_q    <= sts_d;
      if (hnd_en)   in_hnd_q <= hnd_d;
      if (rdata_en) rdata_q  <= rdata_d;
      exc_q <= exc_d;
      gp_q  <= gp_d;
      rdv_q <= rdv_d;
    end
  end

  assign acc_rdata  = rdata_q;
  assign acc_rd_vld = rdv_q;
  assign dbg_exc    = exc_q;
  assign gp_fault   = gp_q;
  assign status     = sts_q;
endmodule

// File: rtl/dbg_guard_chk.sv
module dbg_guard_chk
  import dbg_guard_pkg::*;
#(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    cpl,
  input logic          mgmt_mode,
  input logic          real_mode,
  input logic          acc_rd,
  input logic          acc_wr,
  input logic          hnd_entry,
  input logic [AW-1:0] ctl,
  input logic [AW-1:0] status,
  input logic          dbg_exc,
  input logic          gp_fault,
  input logic          acc_rd_vld
);
  logic any_acc, priv_ok;
  assign any_acc = acc_rd || acc_wr;
  assign priv_ok = mgmt_mode || real_mode || (cpl == 2'd0);

  p_fault_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (any_acc && !priv_ok) |=> (gp_fault && !acc_rd_vld));

  p_permit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (any_acc && priv_ok) |=> !gp_fault);

  p_trap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (any_acc && priv_ok && ctl[GD_BIT]) |=> (dbg_exc && status[BD_BIT] && !acc_rd_vld));

  p_gp_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (any_acc && !priv_ok && !status[BD_BIT]) |=> !status[BD_BIT]);

  p_gd_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hnd_entry |=> !ctl[GD_BIT]);

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_wr |=> ((status & $past(status)) == $past(status)));
endmodule

bind dbg_guard dbg_guard_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .cpl        (cpl),
  .mgmt_mode  (mgmt_mode),
  .real_mode  (real_mode),
  .acc_rd     (acc_rd),
  .acc_wr     (acc_wr),
  .hnd_entry  (hnd_entry),
  .ctl        (ctl_q),
  .status     (sts_q),
  .dbg_exc    (dbg_exc),
  .gp_fault   (gp_fault),
  .acc_rd_vld (acc_rd_vld)
);

// File: tb/dbg_guard_bench.sv
`timescale 1ns/1ps
module dbg_guard_bench;
  localparam int AW = 32;

  logic          clk;
  logic          rst_n;
  logic [1:0]    cpl;
  logic          mgmt_mode, real_mode, acc_rd, acc_wr;
  logic [2:0]    acc_sel;
  logic [AW-1:0] acc_wdata, acc_rdata;
  logic          acc_rd_vld;
  logic          fetch_vld, data_vld;
  logic [AW-1:0] fetch_lin, data_lin;
  logic          hnd_entry, hnd_exit;
  logic          dbg_exc, gp_fault;
  logic [AW-1:0] status;

  dbg_guard #(.AW(AW), .NBP(4)) u_dbg_guard (
    .clk(clk), .rst_n(rst_n), .cpl(cpl), .mgmt_mode(mgmt_mode), .real_mode(real_mode),
    .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_sel(acc_sel), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .acc_rd_vld(acc_rd_vld), .fetch_vld(fetch_vld),
    .fetch_lin(fetch_lin), .data_vld(data_vld), .data_lin(data_lin),
    .hnd_entry(hnd_entry), .hnd_exit(hnd_exit), .dbg_exc(dbg_exc),
    .gp_fault(gp_fault), .status(status)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct {
    int          due;
    logic        gp;
    logic        exc;
    logic        rdv;
    logic [31:0] rdata;
    logic [31:0] sts;
    string       req;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  // Reference state built from the requirements
  logic [31:0] m_bp [4];
  logic [31:0] m_ctl, m_sts;
  logic        m_hnd;
  localparam logic [31:0] CMASK = 32'h0000_200F;
  localparam logic [31:0] SMASK = 32'h0000_200F;

  always @(posedge clk) cyc = cyc + 1;

  // Monitor: pops the items due at this cycle and compares
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      logic ok;
      e = q.pop_front();
      checks++;
      ok = (e.due == cyc) && (gp_fault === e.gp) && (dbg_exc === e.exc) &&
           (acc_rd_vld === e.rdv) && (status === e.sts) &&
           (!e.rdv || acc_rdata === e.rdata);
      if (!ok) begin
        errors++;
        $display("FAIL %s: got gp=%0b exc=%0b rdv=%0b rdata=%h sts=%h, expected gp=%0b exc=%0b rdv=%0b rdata=%h sts=%h",
                 e.req, gp_fault, dbg_exc, acc_rd_vld, acc_rdata, status,
                 e.gp, e.exc, e.rdv, e.rdata, e.sts);
      end
    end
  end

  // Driver: one cycle of stimulus, expected result pushed for the next clock
  task automatic step(input logic [1:0] c, input logic mm, input logic rm,
                      input logic rd, input logic wr, input logic [2:0] sel,
                      input logic [31:0] wd, input logic fv, input logic [31:0] fa,
                      input logic dv, input logic [31:0] da,
                      input logic he, input logic hx, input string req);
    exp_t e;
    logic priv, acc, gp, trap, perf;
    logic [3:0] hits;
    logic [31:0] rv, nsts, nctl;
    @(negedge clk);
    cpl = c; mgmt_mode = mm; real_mode = rm; acc_rd = rd; acc_wr = wr;
    acc_sel = sel; acc_wdata = wd; fetch_vld = fv; fetch_lin = fa;
    data_vld = dv; data_lin = da; hnd_entry = he; hnd_exit = hx;

    priv = mm || rm || (c == 2'd0);
    acc  = rd || wr;
    gp   = acc && !priv;
    trap = acc && priv && m_ctl[13];
    perf = acc && priv && !m_ctl[13];
    for (int i = 0; i < 4; i++)
      hits[i] = m_ctl[i] && !m_hnd && ((fv && fa == m_bp[i]) || (dv && da == m_bp[i]));
    case (sel)
      3'd0, 3'd1, 3'd2, 3'd3: rv = m_bp[sel[1:0]];
      3'd6: rv = m_sts;
      3'd7: rv = m_ctl;
      default: rv = 32'h0;
    endcase
    nsts = (perf && wr && sel == 3'd6) ? (wd & SMASK) : m_sts;
    nsts = nsts | {28'h0, hits};
    if (trap) nsts[13] = 1'b1;
    nctl = (perf && wr && sel == 3'd7) ? (wd & CMASK) : m_ctl;
    if (he) nctl[13] = 1'b0;
    if (perf && wr && sel < 3'd4) m_bp[sel[1:0]] = wd;
    m_sts = nsts;
    m_ctl = nctl;
    if (he) m_hnd = 1'b1;
    else if (hx) m_hnd = 1'b0;

    e.due = cyc + 1; e.gp = gp; e.exc = trap || (|hits); e.rdv = perf && rd;
    e.rdata = rv; e.sts = nsts; e.req = req;
    q.push_back(e);
  endtask

  task automatic wr_reg(input logic [1:0] c, input logic mm, input logic rm,
                        input logic [2:0] sel, input logic [31:0] wd, input string req);
    step(c, mm, rm, 1'b0, 1'b1, sel, wd, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, req);
  endtask

  task automatic rd_reg(input logic [1:0] c, input logic mm, input logic rm,
                        input logic [2:0] sel, input string req);
    step(c, mm, rm, 1'b1, 1'b0, sel, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, req);
  endtask

  task automatic probe(input logic fv, input logic [31:0] fa, input logic dv,
                       input logic [31:0] da, input string req);
    step(2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 32'h0, fv, fa, dv, da, 1'b0, 1'b0, req);
  endtask

  task automatic handler(input logic he, input logic hx, input string req);
    step(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0, he, hx, req);
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) m_bp[i] = 32'h0;
    m_ctl = 32'h0; m_sts = 32'h0; m_hnd = 1'b0;
    rst_n = 1'b0; cpl = 2'd0; mgmt_mode = 1'b0; real_mode = 1'b0;
    acc_rd = 1'b0; acc_wr = 1'b0; acc_sel = 3'd0; acc_wdata = 32'h0;
    fetch_vld = 1'b0; fetch_lin = 32'h0; data_vld = 1'b0; data_lin = 32'h0;
    hnd_entry = 1'b0; hnd_exit = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state at the ports
    checks++;
    if (gp_fault !== 1'b0 || dbg_exc !== 1'b0 || acc_rd_vld !== 1'b0 || status !== 32'h0) begin
      errors++;
      $display("FAIL R1: got gp=%0b exc=%0b rdv=%0b sts=%h, expected all zero",
               gp_fault, dbg_exc, acc_rd_vld, status);
    end
    rd_reg(2'd0, 1'b0, 1'b0, 3'd7, "R1 control zero");
    rd_reg(2'd0, 1'b0, 1'b0, 3'd2, "R1 bp2 zero");

    // R2: unprivileged accesses fault and change nothing
    wr_reg(2'd3, 1'b0, 1'b0, 3'd0, 32'hDEAD_0000, "R2 ring3 write");
    rd_reg(2'd1, 1'b0, 1'b0, 3'd0, "R2 ring1 read");
    rd_reg(2'd0, 1'b0, 1'b0, 3'd0, "R2 bp0 unchanged");

    // R3: each permitted mode
    wr_reg(2'd0, 1'b0, 1'b0, 3'd0, 32'h0000_1000, "R3 ring0 write");
    wr_reg(2'd3, 1'b1, 1'b0, 3'd1, 32'h0000_2000, "R3 mgmt write");
    wr_reg(2'd2, 1'b0, 1'b1, 3'd2, 32'h0000_3000, "R3 real write");
    wr_reg(2'd0, 1'b0, 1'b0, 3'd3, 32'h0000_4000, "R3 ring0 write bp3");
    rd_reg(2'd3, 1'b1, 1'b0, 3'd0, "R3 readback bp0");
    rd_reg(2'd3, 1'b0, 1'b1, 3'd1, "R3 readback bp1");
    rd_reg(2'd0, 1'b0, 1'b0, 3'd2, "R3 readback bp2");
    rd_reg(2'd0, 1'b0, 1'b0, 3'd3, "R3 readback bp3");

    // R11: selects 4 and 5 are inert, control write masking
    wr_reg(2'd0, 1'b0, 1'b0, 3'd4, 32'hFFFF_FFFF, "R11 write sel4");
    wr_reg(2'd0, 1'b0, 1'b0, 3'd5, 32'hFFFF_FFFF, "R11 write sel5");
    rd_reg(2'd0, 1'b0, 1'b0, 3'd4, "R11 read sel4");
    rd_reg(2'd0, 1'b0, 1'b0, 3'd5, "R11 read sel5");
    wr_reg(2'd3, 1'b0, 1'b0, 3'd5, 32'h1, "R11 sel5 unprivileged");
    wr_reg(2'd0, 1'b0, 1'b0, 3'd7, 32'hFFFF_DFF5, "R11 control mask");
    rd_reg(2'd0, 1'b0, 1'b0, 3'd7, "R11 control readback");

    // R7 / R8: comparators 0 and 2 enabled
    probe(1'b1, 32'h0000_1000, 1'b0, 32'h0, "R7 fetch hit bp0");
    probe(1'b0, 32'h0, 1'b1, 32'h0000_3000, "R7 data hit bp2");
    probe(1'b1, 32'h0000_2000, 1'b1, 32'h0000_4000, "R8 disabled bp1 bp3");
    probe(1'b0, 32'h0000_1000, 1'b0, 32'h0000_3000, "R7 valid low no hit");
    probe(1'b1, 32'h0000_1004, 1'b0, 32'h0, "R7 near miss");

    // R9: sticky status and write masking
    probe(1'b0, 32'h0, 1'b0, 32'h0, "R9 status holds");
    wr_reg(2'd0, 1'b0, 1'b0, 3'd6, 32'hFFFF_FFFF, "R9 status write masked");
    wr_reg(2'd0, 1'b0, 1'b0, 3'd6, 32'h0, "R9 status clear");
    step(2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd6, 32'h0, 1'b1, 32'h0000_1000, 1'b0, 32'h0,
         1'b0, 1'b0, "R9 clear with hit ORed");
    wr_reg(2'd0, 1'b0, 1'b0, 3'd6, 32'h0, "R9 status clear again");

    // R10: suppression window
    handler(1'b1, 1'b0, "R10 enter handler");
    probe(1'b1, 32'h0000_1000, 1'b1, 32'h0000_3000, "R10 suppressed hit");
    handler(1'b0, 1'b1, "R10 leave handler");
    probe(1'b1, 32'h0000_1000, 1'b0, 32'h0, "R10 hit after exit");
    wr_reg(2'd0, 1'b0, 1'b0, 3'd6, 32'h0, "R10 status clear");

    // R5 / R4: general detect
    wr_reg(2'd0, 1'b0, 1'b0, 3'd7, 32'h0000_2005, "R4 arm general detect");
    wr_reg(2'd3, 1'b0, 1'b0, 3'd0, 32'h0000_9999, "R5 fault beats trap");
    rd_reg(2'd2, 1'b0, 1'b0, 3'd7, "R5 fault beats trap read");
    wr_reg(2'd0, 1'b0, 1'b0, 3'd0, 32'h0000_7777, "R4 trapped write");
    rd_reg(2'd3, 1'b1, 1'b0, 3'd0, "R4 trapped read");

    // R6: handler entry disarms, explicit write re-arms
    handler(1'b1, 1'b0, "R6 enter handler");
    rd_reg(2'd0, 1'b0, 1'b0, 3'd7, "R6 control after entry");
    rd_reg(2'd0, 1'b0, 1'b0, 3'd0, "R4 bp0 unchanged by trap");
    wr_reg(2'd0, 1'b0, 1'b0, 3'd6, 32'h0, "R6 clear status in handler");
    step(2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd7, 32'h0000_2005, 1'b0, 32'h0, 1'b0, 32'h0,
         1'b0, 1'b1, "R6 rearm at exit");
    rd_reg(2'd0, 1'b0, 1'b0, 3'd6, "R6 rearmed trap");
    step(2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd7, 32'h0000_2005, 1'b0, 32'h0, 1'b0, 32'h0,
         1'b1, 1'b0, "R6 entry beats trapped write");
    rd_reg(2'd0, 1'b0, 1'b0, 3'd7, "R6 control disarmed");
    handler(1'b0, 1'b1, "R6 leave handler");

    // Idle and drain
    probe(1'b0, 32'h0, 1'b0, 32'h0, "R9 final idle");
    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      errors++;
      $display("FAIL drain: %0d items left, expected 0", q.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule